// File: doc/BRIEF.md
# Synchronous Burst SRAM with Write-Control Front End

This block is a small synchronous SRAM with the control logic that sits in front of it. It has a registered address, a two-bit linear burst counter and chip-select decoding. Writes can be full width or limited to some byte lanes, and reads are pipelined. Every control input is sampled on the rising clock edge.

A cycle starts or restarts a burst in one of two ways:

- **Processor strobe (`p_strobe_n`).** The address is taken, but no write happens in that cycle. The cycle after it always uses the address just loaded.
- **Controller strobe (`c_strobe_n`).** The address is taken and any write requested in the same cycle goes to that address at once.

In the cycles that follow a load, the advance input decides the address:

- **Advance low:** the two low address bits step forward and wrap inside a four-word block.
- **Advance high:** the burst holds, and the same word is accessed again.

A controller strobe in the middle of a burst simply starts a new one.

Read data comes out on a separate output bus with its own drive enable, two clock edges after the access cycle. The drive enable is held off whenever the output enable is high or the current cycle is a write. The pins are plain, level-sampled control inputs with no valid/ready handshake, because the access protocol is set by the strobe and advance pins cycle by cycle.

Top module: `sbsram_burst_top`

## Requirements
- R1: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A strobe cycle with any other combination performs no access: nothing is written, nothing is read, and any running burst ends.
- R2: `p_strobe_n` low is ignored while `cs1_n` is high. `c_strobe_n` is honoured regardless of `cs1_n`.
- R3: In a cycle where a processor strobe is accepted, no byte lane is written, whatever the write inputs say.
- R4: A full-width write (all four 9-bit lanes) happens when `gwrite_n`=0. It also happens when `gwrite_n`=1, `bwen_n`=0 and every bit of `lane_wen_n` is 0.
- R5: With `gwrite_n`=1 and `bwen_n`=0, only lane i, bits [9i+8:9i], is written where `lane_wen_n[i]`=0. With `gwrite_n`=1 and `bwen_n`=1 the cycle is a read, and memory does not change.
- R6: In a continuation cycle the access address is chosen as follows:
  - After a processor-strobe load, the first continuation cycle uses the loaded address.
  - Otherwise, `adv_n`=0 adds 1 to address bits [1:0], modulo 4.
  - The upper address bits never change during a burst.
- R7: In a continuation cycle that does not follow a processor-strobe load, `adv_n`=1 keeps the address, so the same word is accessed again.
- R8: An accepted controller strobe during a burst loads the external address and starts a new burst. A write requested in that cycle lands at the new address.
- R9: A read access in cycle n puts its word on `q` with `q_en`=1 during cycle n+2, after two rising edges.
- R10: `q_en` is 0 whenever `oe_n`=1, and whenever the current cycle is an accepted write.
- R11: After reset, `q_en` is 0 and no burst is active. A cycle with no strobe then performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| a | input | ADDR_W | External word address |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| p_strobe_n | input | 1 | Processor-side address strobe, active low |
| c_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the address |
| gwrite_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| lane_wen_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| d | input | LANES*LANE_W | Write data |
| q | output | LANES*LANE_W | Read data |
| q_en | output | 1 | Drive enable for `q` (tri-state control) |

## Verification
The embedded assertions check every cycle for the following:
- deselected strobes never access the array;
- processor-strobe cycles never write;
- the processor strobe is inert while `cs1_n` is high and no burst is running;
- a held burst keeps its address;
- an advanced burst steps only the low two bits;
- the output drive is off when `oe_n` is high or a write is in progress;
- every driven output has a read access two cycles earlier.

Whether the right word reaches the right address can only be shown by the bench scenarios. These cover lane masks, suspend rewrites, mid-burst reloads, wrap-around and the two-cycle read data, all checked against a reference memory.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_LOAD_P = 2'd1,
    CYC_LOAD_C = 2'd2,
    CYC_CONT   = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              p_strobe_n,
  input  logic              c_strobe_n,
  input  logic              adv_n,
  input  logic              gwrite_n,
  input  logic              bwen_n,
  input  logic [LANES-1:0]  lane_wen_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              access,
  output logic [LANES-1:0]  wr_lanes
);
  localparam int HI_W = ADDR_W - 2;

  logic              selected;
  logic              p_take;
  logic              strobe;
  logic [LANES-1:0]  req_lanes;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] step_addr;
  logic              active_q;
  logic              fresh_q;
  cyc_kind_t         kind;

  assign selected = !cs1_n && cs2 && !cs3_n;
  assign p_take   = !p_strobe_n && !cs1_n;
  assign strobe   = p_take || !c_strobe_n;

  always_comb begin
    if (!gwrite_n)     req_lanes = '1;
    else if (!bwen_n)  req_lanes = ~lane_wen_n;
    else               req_lanes = '0;
  end

  always_comb begin
    if (fresh_q || adv_n) step_addr = cur_q;
    else                  step_addr = {cur_q[ADDR_W-1:2], cur_q[1:0] + 2'd1};
  end

  always_comb begin
    if (strobe && selected) kind = p_take ? CYC_LOAD_P : CYC_LOAD_C;
    else if (!strobe && active_q) kind = CYC_CONT;
    else kind = CYC_IDLE;
  end

  always_comb begin
    acc_addr = a;
    access   = 1'b0;
    wr_lanes = '0;
    unique case (kind)
      CYC_LOAD_P: begin
        access = 1'b1;
      end
      CYC_LOAD_C: begin
        access   = 1'b1;
        wr_lanes = req_lanes;
      end
      CYC_CONT: begin
        acc_addr = step_addr;
        access   = 1'b1;
        wr_lanes = req_lanes;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      active_q <= 1'b0;
      fresh_q  <= 1'b0;
    end else if (strobe) begin
      active_q <= selected;
      fresh_q  <= selected && p_take;
      if (selected) cur_q <= a;
    end else if (active_q) begin
      cur_q   <= step_addr;
      fresh_q <= 1'b0;
    end
  end

  // R3: a processor-strobe load never writes
  assert_adsp_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_strobe_n && !cs1_n) |-> (wr_lanes == '0));

  // R2: processor strobe with cs1_n high and no burst running does nothing
  assert_pstrobe_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_strobe_n && cs1_n && c_strobe_n && !active_q) |-> !access);

  // R7: a held burst keeps its address
  assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_CONT && adv_n) |=> $stable(cur_q));

  // R6: an advancing burst steps only the low two bits
  assert_wrap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_CONT && !adv_n && !fresh_q) |=>
      (cur_q[ADDR_W-1:2] == $past(cur_q[ADDR_W-1:2]) &&
       cur_q[1:0] == $past(cur_q[1:0]) + 2'd1));

  // R11: no access from a non-strobe cycle while idle
  assert_idle_noaccess_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !active_q) |-> !access);

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] d,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) mem[acc_addr] <= d[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[acc_addr];
    end
  end
endmodule

// File: rtl/sbsram_rdpipe.sv
module sbsram_rdpipe #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic stage1_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_v  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      stage1_v  <= rd_acc;
      out_valid <= stage1_v;
    end
  end

  always_ff @(posedge clk) begin
    out_data <= rdata;
  end
endmodule

// File: rtl/sbsram_burst_top.sv
module sbsram_burst_top #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       a,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    p_strobe_n,
  input  logic                    c_strobe_n,
  input  logic                    adv_n,
  input  logic                    gwrite_n,
  input  logic                    bwen_n,
  input  logic [LANES-1:0]        lane_wen_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] d,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_en
);
  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] acc_addr;
  logic              access;
  logic [LANES-1:0]  wr_lanes;
  logic [DATA_W-1:0] rdata;
  logic              rd_acc;
  logic              wr_now;
  logic              out_valid;

  sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .a(a),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .p_strobe_n(p_strobe_n), .c_strobe_n(c_strobe_n), .adv_n(adv_n),
    .gwrite_n(gwrite_n), .bwen_n(bwen_n), .lane_wen_n(lane_wen_n),
    .acc_addr(acc_addr), .access(access), .wr_lanes(wr_lanes)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .acc_addr(acc_addr), .wr_lanes(wr_lanes), .d(d), .rdata(rdata)
  );

  assign wr_now = |wr_lanes;
  assign rd_acc = access && !wr_now;

  sbsram_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .rdata(rdata),
    .out_valid(out_valid), .out_data(q)
  );

  assign q_en = out_valid && !oe_n && !wr_now;

  // R1: a deselected controller strobe performs no access
  assert_desel_noaccess_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_strobe_n && !(!cs1_n && cs2 && !cs3_n)) |-> (!access && wr_lanes == '0));

  // R10: output drive is off under oe_n high or an accepted write
  assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || wr_now) |-> !q_en);

  // R9: a driven output has a read access two cycles earlier
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_en |-> $past(rd_acc, 2));
endmodule

// File: tb/sbsram_burst_top_tb.sv
`timescale 1ns/1ps
module sbsram_burst_top_tb;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] a;
  logic              cs1_n, cs2, cs3_n;
  logic              p_strobe_n, c_strobe_n, adv_n;
  logic              gwrite_n, bwen_n;
  logic [LANES-1:0]  lane_wen_n;
  logic              oe_n;
  logic [DATA_W-1:0] d;
  logic [DATA_W-1:0] q;
  logic              q_en;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [DATA_W-1:0] mem_m [DEPTH];
  logic [ADDR_W-1:0] cur_m;
  logic              act_m, fresh_m, v1_m, v2_m;
  logic [DATA_W-1:0] d1_m, d2_m;

  always #2.5 clk = ~clk;

  sbsram_burst_top #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .p_strobe_n(p_strobe_n), .c_strobe_n(c_strobe_n), .adv_n(adv_n),
    .gwrite_n(gwrite_n), .bwen_n(bwen_n), .lane_wen_n(lane_wen_n),
    .oe_n(oe_n), .d(d), .q(q), .q_en(q_en)
  );

  task automatic decode(output logic acc, output logic [ADDR_W-1:0] ea,
                        output logic [LANES-1:0] wl, output logic strobe,
                        output logic sel, output logic ptake);
    logic [LANES-1:0] req;
    sel    = !cs1_n && cs2 && !cs3_n;
    ptake  = !p_strobe_n && !cs1_n;
    strobe = ptake || !c_strobe_n;
    req    = !gwrite_n ? '1 : (!bwen_n ? ~lane_wen_n : '0);
    acc = 1'b0; ea = a; wl = '0;
    if (strobe) begin
      if (sel) begin
        acc = 1'b1;
        wl  = ptake ? '0 : req;
      end
    end else if (act_m) begin
      acc = 1'b1;
      ea  = (fresh_m || adv_n) ? cur_m : {cur_m[ADDR_W-1:2], cur_m[1:0] + 2'd1};
      wl  = req;
    end
  endtask

  task automatic model_step();
    logic acc, strobe, sel, ptake;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0] wl;
    decode(acc, ea, wl, strobe, sel, ptake);
    v2_m = v1_m;
    d2_m = d1_m;
    v1_m = acc && (wl == '0);
    d1_m = mem_m[ea];
    for (int i = 0; i < LANES; i++)
      if (wl[i]) mem_m[ea][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    if (strobe) begin
      act_m   = sel;
      fresh_m = sel && ptake;
      if (sel) cur_m = a;
    end else if (act_m) begin
      cur_m   = ea;
      fresh_m = 1'b0;
    end
  endtask

  // check outputs for the current inputs, then clock one cycle
  task automatic cyc(input string req);
    logic acc, strobe, sel, ptake;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0] wl;
    logic exp_en;
    #1;
    decode(acc, ea, wl, strobe, sel, ptake);
    exp_en = v2_m && !oe_n && (wl == '0);
    checks++;
    if (q_en !== exp_en) begin
      failures++;
      $display("FAIL %s q_en actual=%0b expected=%0b", req, q_en, exp_en);
    end else if (exp_en && q !== d2_m) begin
      failures++;
      $display("FAIL %s q actual=%h expected=%h", req, q, d2_m);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    p_strobe_n = 1'b1; c_strobe_n = 1'b1; adv_n = 1'b1;
    gwrite_n = 1'b1; bwen_n = 1'b1; lane_wen_n = '1; oe_n = 1'b0;
    d = {$urandom, $urandom};
  endtask

  task automatic read_at(input logic [ADDR_W-1:0] ad, input string req);
    idle(); c_strobe_n = 1'b0; a = ad; cyc(req);
    idle(); cyc(req);
    idle(); cyc(req);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); a = '0; rst_n = 1'b0;
    act_m = 0; fresh_m = 0; v1_m = 0; v2_m = 0; cur_m = '0;
    d1_m = '0; d2_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: outputs quiet, continuation cycle with write request does nothing
    idle(); gwrite_n = 1'b0; cyc("R11");
    idle(); cyc("R11");

    // R4: fill memory with controller-strobe full writes via gwrite_n
    for (int i = 0; i < DEPTH; i++) begin
      idle(); c_strobe_n = 1'b0; gwrite_n = 1'b0; a = ADDR_W'(i);
      d = {$urandom, $urandom};
      mem_m[i] = '0;
      for (int l = 0; l < LANES; l++) mem_m[i][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      cyc("R4");
    end
    read_at(6'd5, "R4");
    // R4: full write via bwen_n with all lanes enabled
    idle(); c_strobe_n = 1'b0; bwen_n = 1'b0; lane_wen_n = '0; a = 6'd9; cyc("R4");
    read_at(6'd9, "R4");

    // R3/R6/R7: processor burst at 0x12 with write inputs on the load cycle
    idle(); p_strobe_n = 1'b0; a = 6'h12; gwrite_n = 1'b0; cyc("R3");
    idle(); gwrite_n = 1'b0; adv_n = 1'b0; cyc("R6");      // writes 0x12
    idle(); gwrite_n = 1'b0; adv_n = 1'b0; cyc("R6");      // 0x13
    idle(); gwrite_n = 1'b0; adv_n = 1'b1; cyc("R7");      // 0x13 again
    idle(); gwrite_n = 1'b0; adv_n = 1'b0; cyc("R6");      // 0x10 (wrap)
    idle(); gwrite_n = 1'b0; adv_n = 1'b0; cyc("R6");      // 0x11
    // R8: controller strobe mid-burst, write at new address then advance
    idle(); c_strobe_n = 1'b0; a = 6'h2E; gwrite_n = 1'b0; cyc("R8");
    idle(); gwrite_n = 1'b0; adv_n = 1'b0; cyc("R8");      // 0x2F
    idle(); gwrite_n = 1'b0; adv_n = 1'b0; cyc("R8");      // 0x2C
    for (int i = 0; i < 4; i++) read_at(ADDR_W'(6'h10 + i), "R6");
    read_at(6'h2E, "R8"); read_at(6'h2F, "R8"); read_at(6'h2C, "R8");
    read_at(6'h2D, "R8");

    // R5: partial lanes and the no-write case
    idle(); c_strobe_n = 1'b0; a = 6'h20; bwen_n = 1'b0; lane_wen_n = 4'b1010; cyc("R5");
    idle(); c_strobe_n = 1'b0; a = 6'h21; lane_wen_n = 4'b0000; cyc("R5");
    idle(); cyc("R5"); idle(); cyc("R5");
    read_at(6'h20, "R5"); read_at(6'h21, "R5");

    // R1: deselected controller strobe with write ends burst, nothing written
    idle(); cs2 = 1'b0; c_strobe_n = 1'b0; gwrite_n = 1'b0; a = 6'h30; cyc("R1");
    idle(); cs3_n = 1'b1; c_strobe_n = 1'b0; gwrite_n = 1'b0; a = 6'h31; cyc("R1");
    idle(); gwrite_n = 1'b0; cyc("R1");
    read_at(6'h30, "R1"); read_at(6'h31, "R1");

    // R2: processor strobe with cs1_n high ignored; controller strobe honoured
    idle(); cs1_n = 1'b1; p_strobe_n = 1'b0; c_strobe_n = 1'b1; a = 6'h33; cyc("R2");
    idle(); gwrite_n = 1'b0; cyc("R2");
    read_at(6'h33, "R2");

    // R9/R10: read burst with oe_n toggling and a write colliding with output
    idle(); c_strobe_n = 1'b0; a = 6'h3D; cyc("R9");
    idle(); adv_n = 1'b0; cyc("R9");
    idle(); adv_n = 1'b0; oe_n = 1'b1; cyc("R10");
    idle(); adv_n = 1'b0; gwrite_n = 1'b0; cyc("R10");
    idle(); cyc("R9"); idle(); cyc("R9");
    read_at(6'h3C, "R10");

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      a          = ADDR_W'($urandom);
      cs1_n      = ($urandom_range(0, 9) == 0);
      cs2        = ($urandom_range(0, 9) != 0);
      cs3_n      = ($urandom_range(0, 9) == 0);
      p_strobe_n = ($urandom_range(0, 5) != 0);
      c_strobe_n = ($urandom_range(0, 5) != 0);
      adv_n      = $urandom_range(0, 1);
      gwrite_n   = ($urandom_range(0, 5) != 0);
      bwen_n     = $urandom_range(0, 1);
      lane_wen_n = LANES'($urandom);
      oe_n       = ($urandom_range(0, 7) == 0);
      cyc("R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule